// File: doc/BRIEF.md
# Two-Level Debug Trigger Sequencer

This block watches the event stream a processor core emits every cycle and decides when to raise a breakpoint or trace trigger. The stream has two parts. The first is the program counter of an executed instruction. The second is a bus access, made of an address, 32-bit data, access size and read/write direction.

A configuration port loads the block's settings. These are a program-counter comparator, an address comparator, and a data comparator with an access-type qualifier. The configuration also selects a combining mode. A mode can be a single condition, a same-cycle AND or OR of conditions, or an ordered two-step sequence. In a sequence, the first condition arms the block and a later second condition fires it.

For data matching, the block takes the operand from the byte lane of the 32-bit bus that the low address bits and the access size select. The result appears as a one-cycle trigger pulse and a sticky hit flag. An armed indicator shows when a sequence is half complete. An enable input and a re-arm input let the debug logic hold the block idle or reset its sequence.

Top module: `dbg_trigger_seq`

## Requirements
- R1: After reset, `trigPulse`, `hitFlag` and `seqArmed` are 0. The block holds a non-matching mode until the first configuration write, so no event triggers it before then.
- R2: A matching event cycle sets `trigPulse` high during the next cycle only, and sets `hitFlag`. `hitFlag` stays high until a configuration write or a re-arm.
- R3: Mode codes are 0 anything, 1 PC, 2 address, 3 data, 4 address AND data, 5 PC OR address, 6 PC OR (address AND data), 7 PC THEN address, 8 PC THEN data, 9 PC THEN (address AND data), 10 address THEN PC, 11 data THEN PC, and 12 (address AND data) THEN PC. "Anything" fires on every cycle where `evtPcValid` or `busValid` is high. PC matching needs `evtPcValid` and an equal `evtPc`. Address matching needs `busValid` and an equal `busAddr`.
- R4: The access qualifier `cfgDir` gates address and data matches. 01 accepts reads only, 10 accepts writes only, and 00 or 11 accepts both. `busWrite`=1 marks a write.
- R5: Size codes are 00 byte, 01 word and 10 longword. For a byte access, `busAddr[1:0]` values 00, 01, 10 and 11 take the operand from `busData` bits [31:24], [23:16], [15:8] and [7:0]. The operand is compared with `cfgData[7:0]`.
- R6: For a word access, `busAddr[1]`=0 takes bits [31:16] and `busAddr[1]`=1 takes bits [15:0], compared with `cfgData[15:0]`. A longword access compares all 32 bits. A data match also requires `busSize` to equal `cfgSize`.
- R7: An address AND data condition holds only when address, data value, size and access type all match in the same cycle.
- R8: An OR mode fires when the PC side matches or the other side matches within one cycle.
- R9: A THEN mode arms on its first condition and fires on a strictly later second condition, then disarms. A second condition seen while unarmed does nothing. Both conditions in one cycle only arm the block.
- R10: A configuration write or a `rearm` pulse clears the armed state and `hitFlag` and gives no trigger in that cycle. An armed sequence waits any number of cycles for its second condition.
- R11: While `enable` is 0, the block gives no trigger and the armed state is cleared.
- R12: Mode codes 13 to 15 never trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Sequencer enable; 0 holds it idle |
| rearm | input | 1 | Clears armed state and hit flag |
| cfgWrite | input | 1 | Loads all cfg* fields |
| cfgMode | input | 4 | Combining mode code |
| cfgPc | input | AW | PC compare value |
| cfgAddr | input | AW | Address compare value |
| cfgData | input | 32 | Data compare value, right-aligned |
| cfgSize | input | 2 | Access size the data compare expects |
| cfgDir | input | 2 | Access-type qualifier |
| evtPcValid | input | 1 | An instruction executed this cycle |
| evtPc | input | AW | Its program counter |
| busValid | input | 1 | A bus access happened this cycle |
| busAddr | input | AW | Access address |
| busData | input | 32 | Bus data, all lanes |
| busSize | input | 2 | Access size |
| busWrite | input | 1 | 1 for write, 0 for read |
| trigPulse | output | 1 | One-cycle trigger |
| hitFlag | output | 1 | Sticky trigger-seen flag |
| seqArmed | output | 1 | First level of a THEN mode seen |

## Verification
The bench builds the block with `AW` set to 16. With short addresses, one table row can hold several address, PC and data combinations without losing any comparator logic. The byte and word lane selectors do not depend on `AW`, so every lane and size combination is still covered. Each table row configures a mode and then applies three events. This is enough to show a THEN mode ignoring an early second condition, arming, and then firing.

// File: rtl/dbgtrig_pkg.sv
package dbgtrig_pkg;

  localparam int BUS_W      = 32;
  localparam int BYTE_LANES = BUS_W / 8;
  localparam int HALF_LANES = BUS_W / 16;

  localparam logic [1:0] SIZE_BYTE = 2'b00;
  localparam logic [1:0] SIZE_WORD = 2'b01;
  localparam logic [1:0] SIZE_LONG = 2'b10;

  localparam logic [1:0] DIR_READ  = 2'b01;
  localparam logic [1:0] DIR_WRITE = 2'b10;

  localparam logic [3:0] MODE_ANY          = 4'd0;
  localparam logic [3:0] MODE_PC           = 4'd1;
  localparam logic [3:0] MODE_ADDR         = 4'd2;
  localparam logic [3:0] MODE_DATA         = 4'd3;
  localparam logic [3:0] MODE_AD           = 4'd4;
  localparam logic [3:0] MODE_PC_OR_ADDR   = 4'd5;
  localparam logic [3:0] MODE_PC_OR_AD     = 4'd6;
  localparam logic [3:0] MODE_PC_THEN_ADDR = 4'd7;
  localparam logic [3:0] MODE_PC_THEN_DATA = 4'd8;
  localparam logic [3:0] MODE_PC_THEN_AD   = 4'd9;
  localparam logic [3:0] MODE_ADDR_THEN_PC = 4'd10;
  localparam logic [3:0] MODE_DATA_THEN_PC = 4'd11;
  localparam logic [3:0] MODE_AD_THEN_PC   = 4'd12;
  localparam logic [3:0] MODE_IDLE         = 4'd15;

  // control -> datapath strobes
  typedef struct packed {
    logic loadCfg;
    logic matchEn;
  } ctrlStrobe_t;

  // datapath -> control comparator results
  typedef struct packed {
    logic anyEvt;
    logic pcHit;
    logic addrHit;
    logic dataHit;
  } matchVec_t;

endpackage

// File: rtl/dbgtrig_lane.sv
module dbgtrig_lane
  import dbgtrig_pkg::*;
(
  input  logic [BUS_W-1:0] busData,
  input  logic [1:0]       addrLo,
  input  logic [1:0]       size,
  output logic [BUS_W-1:0] laneVal,
  output logic             sizeOk
);

  logic [7:0]  byteArr [BYTE_LANES];
  logic [15:0] halfArr [HALF_LANES];
  logic [1:0]  byteIdx;
  logic        halfIdx;

  // lane 0 holds the least significant byte; address offset 0 is the most significant lane
  for (genvar i = 0; i < BYTE_LANES; i++) begin : g_byte
    assign byteArr[i] = busData[8*i +: 8];
  end
  for (genvar j = 0; j < HALF_LANES; j++) begin : g_half
    assign halfArr[j] = busData[16*j +: 16];
  end

  assign byteIdx = 2'(BYTE_LANES - 1) - addrLo;
  assign halfIdx = ~addrLo[1];

  always_comb begin
    laneVal = '0;
    sizeOk  = 1'b1;
    unique case (size)
      SIZE_BYTE: laneVal = {{(BUS_W-8){1'b0}},  byteArr[byteIdx]};
      SIZE_WORD: laneVal = {{(BUS_W-16){1'b0}}, halfArr[halfIdx]};
      SIZE_LONG: laneVal = busData;
      default:   sizeOk  = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbgtrig_match.sv
module dbgtrig_match
  import dbgtrig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobe_t      strobe,
  input  logic [3:0]       cfgMode,
  input  logic [AW-1:0]    cfgPc,
  input  logic [AW-1:0]    cfgAddr,
  input  logic [BUS_W-1:0] cfgData,
  input  logic [1:0]       cfgSize,
  input  logic [1:0]       cfgDir,
  input  logic             evtPcValid,
  input  logic [AW-1:0]    evtPc,
  input  logic             busValid,
  input  logic [AW-1:0]    busAddr,
  input  logic [BUS_W-1:0] busData,
  input  logic [1:0]       busSize,
  input  logic             busWrite,
  output matchVec_t        hits,
  output logic [3:0]       modeQ
);

  logic [AW-1:0]    pcQ, addrQ;
  logic [BUS_W-1:0] dataQ, dataMask, laneVal;
  logic [1:0]       sizeQ, dirQ;
  logic             sizeOk, dirOk, accessOk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ <= MODE_IDLE;
      pcQ   <= '0;
      addrQ <= '0;
      dataQ <= '0;
      sizeQ <= SIZE_LONG;
      dirQ  <= '0;
    end else if (strobe.loadCfg) begin
      modeQ <= cfgMode;
      pcQ   <= cfgPc;
      addrQ <= cfgAddr;
      dataQ <= cfgData;
      sizeQ <= cfgSize;
      dirQ  <= cfgDir;
    end
  end

  dbgtrig_lane u_lane (
    .busData (busData),
    .addrLo  (busAddr[1:0]),
    .size    (busSize),
    .laneVal (laneVal),
    .sizeOk  (sizeOk)
  );

  always_comb begin
    unique case (dirQ)
      DIR_READ:  dirOk = !busWrite;
      DIR_WRITE: dirOk = busWrite;
      default:   dirOk = 1'b1;
    endcase
  end

  always_comb begin
    unique case (sizeQ)
      SIZE_BYTE: dataMask = {{(BUS_W-8){1'b0}},  8'hFF};
      SIZE_WORD: dataMask = {{(BUS_W-16){1'b0}}, 16'hFFFF};
      default:   dataMask = '1;
    endcase
  end

  assign accessOk = strobe.matchEn && busValid && dirOk;

  assign hits.anyEvt  = strobe.matchEn && (evtPcValid || busValid);
  assign hits.pcHit   = strobe.matchEn && evtPcValid && (evtPc == pcQ);
  assign hits.addrHit = accessOk && (busAddr == addrQ);
  assign hits.dataHit = accessOk && sizeOk && (busSize == sizeQ) &&
                        (laneVal == (dataQ & dataMask));

endmodule

// File: rtl/dbgtrig_ctrl.sv
module dbgtrig_ctrl
  import dbgtrig_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        rearm,
  input  logic        cfgWrite,
  input  logic [3:0]  modeQ,
  input  matchVec_t   hits,
  output ctrlStrobe_t strobe,
  output logic        trigPulse,
  output logic        hitFlag,
  output logic        seqArmed
);

  logic armedQ, trigQ, hitQ;
  logic adHit, isThen, singleHit, firstHit, secondHit, fire, armNext;

  assign strobe.loadCfg = cfgWrite;
  assign strobe.matchEn = enable && !cfgWrite && !rearm;

  assign adHit = hits.addrHit && hits.dataHit;

  always_comb begin
    isThen    = 1'b0;
    singleHit = 1'b0;
    firstHit  = 1'b0;
    secondHit = 1'b0;
    case (modeQ)
      MODE_ANY:        singleHit = hits.anyEvt;
      MODE_PC:         singleHit = hits.pcHit;
      MODE_ADDR:       singleHit = hits.addrHit;
      MODE_DATA:       singleHit = hits.dataHit;
      MODE_AD:         singleHit = adHit;
      MODE_PC_OR_ADDR: singleHit = hits.pcHit || hits.addrHit;
      MODE_PC_OR_AD:   singleHit = hits.pcHit || adHit;
      MODE_PC_THEN_ADDR: begin isThen = 1'b1; firstHit = hits.pcHit;   secondHit = hits.addrHit; end
      MODE_PC_THEN_DATA: begin isThen = 1'b1; firstHit = hits.pcHit;   secondHit = hits.dataHit; end
      MODE_PC_THEN_AD:   begin isThen = 1'b1; firstHit = hits.pcHit;   secondHit = adHit;        end
      MODE_ADDR_THEN_PC: begin isThen = 1'b1; firstHit = hits.addrHit; secondHit = hits.pcHit;   end
      MODE_DATA_THEN_PC: begin isThen = 1'b1; firstHit = hits.dataHit; secondHit = hits.pcHit;   end
      MODE_AD_THEN_PC:   begin isThen = 1'b1; firstHit = adHit;        secondHit = hits.pcHit;   end
      default: ;
    endcase
  end

  assign fire    = isThen ? (armedQ && secondHit) : singleHit;
  assign armNext = isThen ? (armedQ ? !secondHit : firstHit) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armedQ <= 1'b0;
      trigQ  <= 1'b0;
      hitQ   <= 1'b0;
    end else if (cfgWrite || rearm) begin
      armedQ <= 1'b0;
      trigQ  <= 1'b0;
      hitQ   <= 1'b0;
    end else if (!enable) begin
      armedQ <= 1'b0;
      trigQ  <= 1'b0;
    end else begin
      armedQ <= armNext;
      trigQ  <= fire;
      hitQ   <= hitQ || fire;
    end
  end

  assign trigPulse = trigQ;
  assign hitFlag   = hitQ;
  assign seqArmed  = armedQ;

endmodule

// File: rtl/dbg_trigger_seq.sv
module dbg_trigger_seq
  import dbgtrig_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rearm,
  input  logic             cfgWrite,
  input  logic [3:0]       cfgMode,
  input  logic [AW-1:0]    cfgPc,
  input  logic [AW-1:0]    cfgAddr,
  input  logic [31:0]      cfgData,
  input  logic [1:0]       cfgSize,
  input  logic [1:0]       cfgDir,
  input  logic             evtPcValid,
  input  logic [AW-1:0]    evtPc,
  input  logic             busValid,
  input  logic [AW-1:0]    busAddr,
  input  logic [31:0]      busData,
  input  logic [1:0]       busSize,
  input  logic             busWrite,
  output logic             trigPulse,
  output logic             hitFlag,
  output logic             seqArmed
);

  ctrlStrobe_t strobe;
  matchVec_t   hits;
  logic [3:0]  modeQ;

  dbgtrig_match #(.AW(AW)) u_match (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cfgMode    (cfgMode),
    .cfgPc      (cfgPc),
    .cfgAddr    (cfgAddr),
    .cfgData    (cfgData),
    .cfgSize    (cfgSize),
    .cfgDir     (cfgDir),
    .evtPcValid (evtPcValid),
    .evtPc      (evtPc),
    .busValid   (busValid),
    .busAddr    (busAddr),
    .busData    (busData),
    .busSize    (busSize),
    .busWrite   (busWrite),
    .hits       (hits),
    .modeQ      (modeQ)
  );

  dbgtrig_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .rearm     (rearm),
    .cfgWrite  (cfgWrite),
    .modeQ     (modeQ),
    .hits      (hits),
    .strobe    (strobe),
    .trigPulse (trigPulse),
    .hitFlag   (hitFlag),
    .seqArmed  (seqArmed)
  );

endmodule

// File: rtl/dbgtrig_chk.sv
module dbgtrig_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       enable,
  input logic       rearm,
  input logic       cfgWrite,
  input logic [3:0] modeQ,
  input logic       trigPulse,
  input logic       hitFlag,
  input logic       seqArmed
);

  AST_HIT_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    trigPulse |-> hitFlag);                                            // R2

  AST_HIT_RISES_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hitFlag) |-> trigPulse);                                     // R2

  AST_CLEAR_ON_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrite || rearm) |=> (!seqArmed && !hitFlag && !trigPulse));    // R10

  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!trigPulse && !seqArmed));                            // R11

  AST_ARMED_ONLY_THEN: assert property (@(posedge clk) disable iff (!rst_n)
    seqArmed |-> (modeQ inside {[4'd7:4'd12]}));                       // R9

  AST_THEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!seqArmed && (modeQ inside {[4'd7:4'd12]})) |=> !trigPulse);      // R9

  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (modeQ > 4'd12) |=> !trigPulse);                                   // R12

endmodule

bind dbg_trigger_seq dbgtrig_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .rearm     (rearm),
  .cfgWrite  (cfgWrite),
  .modeQ     (modeQ),
  .trigPulse (trigPulse),
  .hitFlag   (hitFlag),
  .seqArmed  (seqArmed)
);

// File: tb/dbg_trigger_seq_bench.sv
module dbg_trigger_seq_bench;

  localparam int AW = 16;

  typedef struct packed {
    logic          pcV;
    logic [AW-1:0] pc;
    logic          bV;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [1:0]    size;
    logic          wr;
    logic          exp;
  } evt_t;

  typedef struct packed {
    logic [3:0]    req;
    logic [3:0]    mode;
    logic [AW-1:0] pc;
    logic [AW-1:0] addr;
    logic [31:0]   data;
    logic [1:0]    size;
    logic [1:0]    dir;
    evt_t          a;
    evt_t          b;
    evt_t          c;
  } vec_t;

  function automatic evt_t idleE(logic e);
    return '{1'b0, 16'h0, 1'b0, 16'h0, 32'h0, 2'b10, 1'b0, e};
  endfunction
  function automatic evt_t pcE(logic [AW-1:0] p, logic e);
    return '{1'b1, p, 1'b0, 16'h0, 32'h0, 2'b10, 1'b0, e};
  endfunction
  function automatic evt_t busE(logic [AW-1:0] ad, logic [31:0] d, logic [1:0] s, logic w, logic e);
    return '{1'b0, 16'h0, 1'b1, ad, d, s, w, e};
  endfunction
  function automatic evt_t bothE(logic [AW-1:0] p, logic [AW-1:0] ad, logic [31:0] d, logic [1:0] s, logic w, logic e);
    return '{1'b1, p, 1'b1, ad, d, s, w, e};
  endfunction

  localparam logic [1:0] B = 2'b00, W = 2'b01, L = 2'b10;
  localparam int NV = 18;

  // req, mode, cfgPc, cfgAddr, cfgData, cfgSize, cfgDir, three events with expected pulse
  localparam vec_t VEC [NV] = '{
    '{4'd3, 4'd0, 16'h0100, 16'h2002, 32'h0, L, 2'b00, idleE(0), pcE(16'h0777,1), busE(16'h1234,32'h0,L,0,1)},
    '{4'd3, 4'd1, 16'h0100, 16'h2002, 32'h0, L, 2'b00, pcE(16'h0104,0), pcE(16'h0100,1), busE(16'h0100,32'h0,L,0,0)},
    '{4'd3, 4'd2, 16'h0100, 16'h2002, 32'h0, L, 2'b00, busE(16'h2003,32'h0,L,0,0), busE(16'h2002,32'h0,B,1,1), pcE(16'h2002,0)},
    '{4'd5, 4'd3, 16'h0100, 16'h2002, 32'hA5, B, 2'b00, busE(16'h3001,32'h0000A500,B,0,0), busE(16'h3001,32'h00A50000,B,0,1), busE(16'h3000,32'hA5000000,B,1,1)},
    '{4'd5, 4'd3, 16'h0100, 16'h2002, 32'hA5, B, 2'b00, busE(16'h3003,32'hA5000000,B,0,0), busE(16'h3003,32'h000000A5,B,0,1), busE(16'h3002,32'h0000A500,B,0,1)},
    '{4'd6, 4'd3, 16'h0100, 16'h2002, 32'hBEEF, W, 2'b00, busE(16'h4002,32'hBEEF0000,W,0,0), busE(16'h4002,32'h0000BEEF,W,0,1), busE(16'h4000,32'hBEEF0000,W,0,1)},
    '{4'd6, 4'd3, 16'h0100, 16'h2002, 32'hBEEF, W, 2'b00, busE(16'h4000,32'hBEEF0000,B,0,0), busE(16'h4000,32'hBEEFBEEF,L,0,0), busE(16'h4000,32'hBEEF1111,W,1,1)},
    '{4'd4, 4'd3, 16'h0100, 16'h2002, 32'h12345678, L, 2'b10, busE(16'h5000,32'h12345678,L,0,0), busE(16'h5000,32'h12345678,L,1,1), busE(16'h5000,32'h12345679,L,1,0)},
    '{4'd7, 4'd4, 16'h0100, 16'h2002, 32'hCAFEF00D, L, 2'b01, busE(16'h2002,32'hCAFEF00E,L,0,0), busE(16'h2002,32'hCAFEF00D,L,0,1), busE(16'h2002,32'hCAFEF00D,L,1,0)},
    '{4'd8, 4'd5, 16'h0100, 16'h2002, 32'h0, L, 2'b00, pcE(16'h0100,1), busE(16'h2002,32'h0,L,0,1), busE(16'h2006,32'h0,L,0,0)},
    '{4'd8, 4'd6, 16'h0100, 16'h2002, 32'hCAFEF00D, L, 2'b00, busE(16'h2002,32'h0,L,0,0), busE(16'h2002,32'hCAFEF00D,L,1,1), pcE(16'h0100,1)},
    '{4'd9, 4'd7, 16'h0100, 16'h2002, 32'h0, L, 2'b00, busE(16'h2002,32'h0,L,0,0), pcE(16'h0100,0), busE(16'h2002,32'h0,L,0,1)},
    '{4'd9, 4'd8, 16'h0100, 16'h2002, 32'h5A, B, 2'b00, pcE(16'h0100,0), idleE(0), busE(16'h3000,32'h5A000000,B,0,1)},
    '{4'd9, 4'd9, 16'h0100, 16'h2002, 32'h5A, B, 2'b00, pcE(16'h0100,0), busE(16'h2002,32'h5A000000,B,0,0), busE(16'h2002,32'h00005A00,B,0,1)},
    '{4'd9, 4'd10, 16'h0100, 16'h2002, 32'h0, L, 2'b00, pcE(16'h0100,0), busE(16'h2002,32'h0,L,0,0), pcE(16'h0100,1)},
    '{4'd9, 4'd11, 16'h0100, 16'h2002, 32'h12345678, L, 2'b00, busE(16'h6000,32'h12345678,L,0,0), pcE(16'h0100,1), pcE(16'h0100,0)},
    '{4'd9, 4'd12, 16'h0100, 16'h2002, 32'h12345678, L, 2'b00, bothE(16'h0100,16'h2002,32'h12345678,L,0,0), idleE(0), pcE(16'h0100,1)},
    '{4'd12, 4'd13, 16'h0100, 16'h2002, 32'h0, L, 2'b00, pcE(16'h0100,0), busE(16'h2002,32'h0,L,0,0), bothE(16'h0100,16'h2002,32'h0,L,0,0)}
  };

  logic clk = 1'b0;
  logic rst_n, enable, rearm, cfgWrite;
  logic [3:0] cfgMode;
  logic [AW-1:0] cfgPc, cfgAddr, evtPc, busAddr;
  logic [31:0] cfgData, busData;
  logic [1:0] cfgSize, cfgDir, busSize;
  logic evtPcValid, busValid, busWrite;
  logic trigPulse, hitFlag, seqArmed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_trigger_seq #(.AW(AW)) u_dbg_trigger_seq (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rearm(rearm), .cfgWrite(cfgWrite),
    .cfgMode(cfgMode), .cfgPc(cfgPc), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .cfgSize(cfgSize), .cfgDir(cfgDir), .evtPcValid(evtPcValid), .evtPc(evtPc),
    .busValid(busValid), .busAddr(busAddr), .busData(busData), .busSize(busSize),
    .busWrite(busWrite), .trigPulse(trigPulse), .hitFlag(hitFlag), .seqArmed(seqArmed)
  );

  function automatic string reqName(logic [3:0] n);
    case (n)
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic drive(evt_t e);
    evtPcValid = e.pcV; evtPc = e.pc;
    busValid = e.bV; busAddr = e.addr; busData = e.data; busSize = e.size; busWrite = e.wr;
  endtask

  task automatic doCfg(logic [3:0] m, logic [AW-1:0] p, logic [AW-1:0] a,
                       logic [31:0] d, logic [1:0] s, logic [1:0] dr);
    cfgMode = m; cfgPc = p; cfgAddr = a; cfgData = d; cfgSize = s; cfgDir = dr;
    drive(idleE(0));
    cfgWrite = 1'b1;
    @(negedge clk);
    cfgWrite = 1'b0;
    check("R10", "hit cleared by config write", hitFlag, 1'b0);
    check("R10", "armed cleared by config write", seqArmed, 1'b0);
  endtask

  task automatic step(evt_t e, string req, string what);
    drive(e);
    @(negedge clk);
    check(req, what, trigPulse, e.exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; rearm = 1'b0; cfgWrite = 1'b0;
    cfgMode = '0; cfgPc = '0; cfgAddr = '0; cfgData = '0; cfgSize = '0; cfgDir = '0;
    drive(idleE(0));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, nothing fires before configuration
    check("R1", "trig after reset", trigPulse, 1'b0);
    check("R1", "hit after reset", hitFlag, 1'b0);
    check("R1", "armed after reset", seqArmed, 1'b0);
    step(bothE(16'h0000, 16'h0000, 32'h0, L, 0, 0), "R1", "event before config");
    check("R1", "hit before config", hitFlag, 1'b0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic hitExp;
      hitExp = 1'b0;
      doCfg(VEC[i].mode, VEC[i].pc, VEC[i].addr, VEC[i].data, VEC[i].size, VEC[i].dir);
      step(VEC[i].a, reqName(VEC[i].req), $sformatf("vec %0d ev a", i));
      hitExp = hitExp | VEC[i].a.exp;
      check("R2", $sformatf("vec %0d hit a", i), hitFlag, hitExp);
      step(VEC[i].b, reqName(VEC[i].req), $sformatf("vec %0d ev b", i));
      hitExp = hitExp | VEC[i].b.exp;
      check("R2", $sformatf("vec %0d hit b", i), hitFlag, hitExp);
      step(VEC[i].c, reqName(VEC[i].req), $sformatf("vec %0d ev c", i));
      hitExp = hitExp | VEC[i].c.exp;
      check("R2", $sformatf("vec %0d hit c", i), hitFlag, hitExp);
    end

    // R2: pulse lasts one cycle, hit stays
    doCfg(4'd1, 16'h0100, 16'h2002, 32'h0, L, 2'b00);
    step(pcE(16'h0100, 1), "R2", "pulse on match");
    step(idleE(0), "R2", "pulse drops next cycle");
    check("R2", "hit sticky", hitFlag, 1'b1);

    // R11: disable suppresses and clears armed state
    enable = 1'b0;
    step(pcE(16'h0100, 0), "R11", "disabled match");
    enable = 1'b1;
    step(pcE(16'h0100, 1), "R11", "re-enabled match");
    doCfg(4'd7, 16'h0100, 16'h2002, 32'h0, L, 2'b00);
    step(pcE(16'h0100, 0), "R9", "first level arms");
    check("R9", "armed after first level", seqArmed, 1'b1);
    enable = 1'b0;
    step(idleE(0), "R11", "disable cycle");
    check("R11", "armed cleared by disable", seqArmed, 1'b0);
    enable = 1'b1;
    step(busE(16'h2002, 32'h0, L, 0, 0), "R11", "second level after disable");

    // R10: armed waits indefinitely, rearm clears
    step(pcE(16'h0100, 0), "R10", "arm again");
    for (int k = 0; k < 40; k++) step(idleE(0), "R10", "armed wait");
    check("R10", "still armed after long wait", seqArmed, 1'b1);
    rearm = 1'b1;
    step(busE(16'h2002, 32'h0, L, 0, 0), "R10", "second level during rearm");
    rearm = 1'b0;
    check("R10", "armed cleared by rearm", seqArmed, 1'b0);
    step(busE(16'h2002, 32'h0, L, 0, 0), "R10", "second level after rearm");
    step(pcE(16'h0100, 0), "R10", "arm after rearm");
    step(busE(16'h2002, 32'h0, L, 0, 1), "R10", "fire after rearm");
    check("R10", "hit set", hitFlag, 1'b1);
    rearm = 1'b1;
    step(idleE(0), "R10", "rearm cycle");
    rearm = 1'b0;
    check("R10", "hit cleared by rearm", hitFlag, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

endmodule